// File: doc/BRIEF.md
# Burst-Mode Power-Down Sampling Controller

This controller runs on the host side of a parallel-output, multi-channel 8-bit converter that is kept asleep between measurements. A run-time interval counter holds the converter powered down. When the interval expires, the controller raises the wake line, waits out the power-up and track time, and then takes one conversion for each entry of a run-time list of 3-bit channel codes. Each conversion uses the write-then-read strobe sequence and waits for the active-low end-of-conversion flag. The controller then deselects the converter, powers it down again and restarts the interval.

Each captured byte leaves on a one-cycle valid/data stream tagged with its channel code. All delays are counted in system clocks from parameters. The converter's end-of-conversion flag and data bus are assumed to be synchronous to the system clock. The first result after reset is dropped, because the converter's first conversion after power-up is not trustworthy. If the flag never comes, a timeout ends the burst and raises an error pulse.

Top module: `burst_sampler`

## Requirements
- R1: During and right after reset, the converter is asleep (`adc_wake` = 0), `adc_cs_n`, `adc_wr_n` and `adc_rd_n` are high, and `smp_valid` and `timeout_err` are low.
- R2: While `enable` is high, the converter stays asleep for exactly `interval`+1 clock cycles after a burst ends, and then `adc_wake` rises. While `enable` is low, it stays asleep.
- R3: The first write strobe of a burst falls no earlier than WAKE_CYC+ACQ_CYC cycles after `adc_wake` rises.
- R4: `adc_addr` is stable for at least ACQ_CYC cycles before each falling edge of `adc_wr_n`, and it stays stable while `adc_wr_n` is low.
- R5: At least ACQ_CYC cycles pass between the end-of-conversion flag going low and the next falling edge of `adc_wr_n`.
- R6: `adc_wr_n` is low for exactly WR_CYC cycles and `adc_rd_n` for exactly RD_CYC cycles. The two strobes are never low together, and neither is low unless `adc_cs_n` is low.
- R7: List slot k sits at bits [3k+2:3k] of `chan_list`, and slots are converted in order 0, 1, 2 and so on. The 3-bit code is driven on `adc_addr` unchanged (000 is the first input, 111 the eighth, which reads full scale). Each result appears on `smp_data` with `smp_chan` equal to its code, and `smp_valid` is high for one cycle.
- R8: A `burst_len` of 0 takes one conversion. A value above SLOTS takes SLOTS conversions. Any other value takes exactly that many.
- R9: The first conversion result after reset is not delivered. All later results are delivered.
- R10: If the flag stays high for TIMEOUT_CYC cycles after the write strobe, `timeout_err` pulses for one cycle with all strobes and the chip select high. The burst then ends with no sample and the converter goes back to sleep.
- R11: `adc_wake` falls only after `adc_cs_n` and `adc_rd_n` have both been high for at least one full cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows the interval counter to run and bursts to start |
| interval | input | IVL_W | Sleep length in clocks, minus one |
| burst_len | input | LEN_W | Number of list slots converted per burst |
| chan_list | input | SLOTS*3 | Packed channel-code list, slot 0 in the low bits |
| adc_wake | output | 1 | Converter power control, 1 = awake |
| adc_addr | output | 3 | Channel address to the converter |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_wr_n | output | 1 | Conversion-start strobe, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_int_n | input | 1 | End-of-conversion flag, active low |
| adc_data | input | 8 | Converter data bus |
| smp_valid | output | 1 | Sample valid, one cycle per result |
| smp_data | output | 8 | Captured result |
| smp_chan | output | 3 | Channel code of the result |
| timeout_err | output | 1 | One-cycle pulse on a missing end-of-conversion flag |

## Verification
The bench builds the block with four list slots, an 8-bit interval and short delays: wake 4, acquisition 3, write 2, read 2 and timeout 12 clocks. With these values, one burst lasts a few dozen cycles, so many bursts fit in one run. A burst length of 7 exceeds the slot count and exercises clipping, and an interval of 0 exercises the one-cycle sleep. A converter model in the bench answers each write strobe after a fixed delay with a byte derived from the channel code, and can be told to withhold the flag so that the timeout path runs.

// File: rtl/burst_pkg.sv
// Shared types for the burst sampling controller.
package burst_pkg;

    // Scheduler phases; the order has no encoding dependency.
    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_WAKE,
        ST_ACQ,
        ST_WRLO,
        ST_WAIT,
        ST_RDLO,
        ST_RDEND,
        ST_DONE
    } bst_t;

endpackage

// File: rtl/burst_sleep_timer.sv
// Sleep interval counter.
// Counts clocks while the scheduler sleeps and reports when the programmed
// interval has elapsed. It is cleared when a burst ends.
// Assumes: interval may change at any time; comparison is live.
module burst_sleep_timer #(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [IVL_W-1:0] interval,
    output logic             expired
);

    logic [IVL_W-1:0] cnt_q;

    assign expired = (cnt_q >= interval);

    // Advance while sleeping, restart at burst end.
    always_ff @(posedge clk) begin : ivl_count
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + IVL_W'(1);
        end
    end

endmodule

// File: rtl/burst_slot_pick.sv
// Channel list lookup.
// Unpacks the channel list, returns the code of the current slot and of the
// following slot, and flags the last slot of the clipped burst length.
// Assumes: idx never exceeds the effective length minus one.
module burst_slot_pick #(
    parameter int SLOTS  = 8,
    parameter int CH_W   = 3,
    parameter int SLOT_W = 3,
    parameter int LEN_W  = 4
) (
    input  logic [SLOTS*CH_W-1:0] chan_list,
    input  logic [SLOT_W-1:0]     idx,
    input  logic [LEN_W-1:0]      burst_len,
    output logic [CH_W-1:0]       chan_cur,
    output logic [CH_W-1:0]       chan_nxt,
    output logic                  is_last
);

    logic [CH_W-1:0]   tbl [SLOTS];
    logic [SLOT_W-1:0] idx_nxt;
    logic [LEN_W-1:0]  eff_len;

    for (genvar g = 0; g < SLOTS; g++) begin : g_unpack
        assign tbl[g] = chan_list[g*CH_W +: CH_W];
    end

    assign idx_nxt = idx + SLOT_W'(1);

    // Select slot codes with a guard for non-power-of-two slot counts.
    always_comb begin : slot_select
        chan_cur = (int'(idx) < SLOTS) ? tbl[idx] : '0;
        chan_nxt = (int'(idx_nxt) < SLOTS) ? tbl[idx_nxt] : '0;
    end

    // Clip the requested length to 1..SLOTS and detect the final slot.
    always_comb begin : len_clip
        if (burst_len == '0) begin
            eff_len = LEN_W'(1);
        end else if (int'(burst_len) > SLOTS) begin
            eff_len = LEN_W'(SLOTS);
        end else begin
            eff_len = burst_len;
        end
        is_last = ((LEN_W'(idx) + LEN_W'(1)) == eff_len);
    end

endmodule

// File: rtl/burst_sampler.sv
// Burst-mode power-down sampling controller (top).
// Sleeps for a run-time interval, wakes the converter, then for each list
// slot: sets the address, waits acquisition, pulses the write strobe, waits
// for the end-of-conversion flag (with timeout), pulses the read strobe and
// captures the byte. Deselects, then powers the converter down.
// Assumes: adc_int_n and adc_data are synchronous to clk; every *_CYC >= 1.
module burst_sampler #(
    parameter int SLOTS       = 8,
    parameter int IVL_W       = 16,
    parameter int WAKE_CYC    = 36,
    parameter int ACQ_CYC     = 16,
    parameter int WR_CYC      = 25,
    parameter int RD_CYC      = 25,
    parameter int TIMEOUT_CYC = 100,
    localparam int CH_W       = 3,
    localparam int DATA_W     = 8,
    localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int LEN_W      = $clog2(SLOTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [IVL_W-1:0]      interval,
    input  logic [LEN_W-1:0]      burst_len,
    input  logic [SLOTS*CH_W-1:0] chan_list,
    output logic                  adc_wake,
    output logic [CH_W-1:0]       adc_addr,
    output logic                  adc_cs_n,
    output logic                  adc_wr_n,
    output logic                  adc_rd_n,
    input  logic                  adc_int_n,
    input  logic [DATA_W-1:0]     adc_data,
    output logic                  smp_valid,
    output logic [DATA_W-1:0]     smp_data,
    output logic [CH_W-1:0]       smp_chan,
    output logic                  timeout_err
);
    import burst_pkg::*;

    localparam int MAX_A  = (WAKE_CYC > ACQ_CYC) ? WAKE_CYC : ACQ_CYC;
    localparam int MAX_B  = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAXD   = (MAX_C > TIMEOUT_CYC) ? MAX_C : TIMEOUT_CYC;
    localparam int DLY_W  = $clog2(MAXD + 1);

    bst_t              st_q;
    logic [DLY_W-1:0]  dly_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CH_W-1:0]   addr_q;
    logic              first_q;
    logic              valid_q;
    logic [DATA_W-1:0] data_q;
    logic [CH_W-1:0]   chan_q;
    logic              err_q;

    logic              ivl_done;
    logic [CH_W-1:0]   pick_cur;
    logic [CH_W-1:0]   pick_nxt;
    logic              pick_last;

    burst_sleep_timer #(
        .IVL_W (IVL_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      ((st_q == ST_SLEEP) && enable),
        .clear    (st_q == ST_DONE),
        .interval (interval),
        .expired  (ivl_done)
    );

    burst_slot_pick #(
        .SLOTS  (SLOTS),
        .CH_W   (CH_W),
        .SLOT_W (SLOT_W),
        .LEN_W  (LEN_W)
    ) u_pick (
        .chan_list (chan_list),
        .idx       (slot_q),
        .burst_len (burst_len),
        .chan_cur  (pick_cur),
        .chan_nxt  (pick_nxt),
        .is_last   (pick_last)
    );

    // Burst scheduler: phase sequencing, delay counting and capture.
    always_ff @(posedge clk) begin : sched
        if (!rst_n) begin
            st_q    <= ST_SLEEP;
            dly_q   <= '0;
            slot_q  <= '0;
            addr_q  <= '0;
            first_q <= 1'b1;
            valid_q <= 1'b0;
            data_q  <= '0;
            chan_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            unique case (st_q)
                ST_SLEEP: begin
                    if (enable && ivl_done) begin
                        st_q   <= ST_WAKE;
                        dly_q  <= '0;
                        slot_q <= '0;
                    end
                end
                ST_WAKE: begin
                    if (dly_q == DLY_W'(WAKE_CYC - 1)) begin
                        st_q   <= ST_ACQ;
                        dly_q  <= '0;
                        addr_q <= pick_cur;
                    end else begin
                        dly_q <= dly_q + DLY_W'(1);
                    end
                end
                ST_ACQ: begin
                    if (dly_q == DLY_W'(ACQ_CYC - 1)) begin
                        st_q  <= ST_WRLO;
                        dly_q <= '0;
                    end else begin
                        dly_q <= dly_q + DLY_W'(1);
                    end
                end
                ST_WRLO: begin
                    if (dly_q == DLY_W'(WR_CYC - 1)) begin
                        st_q  <= ST_WAIT;
                        dly_q <= '0;
                    end else begin
                        dly_q <= dly_q + DLY_W'(1);
                    end
                end
                ST_WAIT: begin
                    if (!adc_int_n) begin
                        st_q  <= ST_RDLO;
                        dly_q <= '0;
                    end else if (dly_q == DLY_W'(TIMEOUT_CYC - 1)) begin
                        st_q  <= ST_DONE;
                        err_q <= 1'b1;
                    end else begin
                        dly_q <= dly_q + DLY_W'(1);
                    end
                end
                ST_RDLO: begin
                    if (dly_q == DLY_W'(RD_CYC - 1)) begin
                        st_q <= ST_RDEND;
                        if (first_q) begin
                            first_q <= 1'b0;
                        end else begin
                            valid_q <= 1'b1;
                            data_q  <= adc_data;
                            chan_q  <= addr_q;
                        end
                    end else begin
                        dly_q <= dly_q + DLY_W'(1);
                    end
                end
                ST_RDEND: begin
                    if (pick_last) begin
                        st_q <= ST_DONE;
                    end else begin
                        st_q   <= ST_ACQ;
                        dly_q  <= '0;
                        slot_q <= slot_q + SLOT_W'(1);
                        addr_q <= pick_nxt;
                    end
                end
                ST_DONE: begin
                    st_q <= ST_SLEEP;
                end
                default: st_q <= ST_SLEEP;
            endcase
        end
    end

    // Converter pin decode from the registered phase.
    always_comb begin : pin_decode
        adc_wake = (st_q != ST_SLEEP);
        adc_cs_n = !((st_q == ST_ACQ) || (st_q == ST_WRLO) || (st_q == ST_WAIT) ||
                     (st_q == ST_RDLO) || (st_q == ST_RDEND));
        adc_wr_n = (st_q != ST_WRLO);
        adc_rd_n = (st_q != ST_RDLO);
    end

    assign adc_addr    = addr_q;
    assign smp_valid   = valid_q;
    assign smp_data    = data_q;
    assign smp_chan    = chan_q;
    assign timeout_err = err_q;

endmodule

// File: rtl/burst_sampler_chk.sv
// Protocol checker for burst_sampler, attached by bind.
// Watches only the top-level pins.
module burst_sampler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       adc_wake,
    input logic [2:0] adc_addr,
    input logic       adc_cs_n,
    input logic       adc_wr_n,
    input logic       adc_rd_n,
    input logic       smp_valid,
    input logic       timeout_err
);

    // R11
    pwr_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_wake) |-> ($past(adc_cs_n) && $past(adc_rd_n)));

    // R11
    sleep_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_wake |-> adc_cs_n);

    // R6
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!adc_wr_n && !adc_rd_n));

    // R6
    strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_wr_n || !adc_rd_n) |-> !adc_cs_n);

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_wr_n && !$past(adc_wr_n)) |-> $stable(adc_addr));

    // R10
    err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (adc_cs_n && adc_wr_n && adc_rd_n));

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

endmodule

bind burst_sampler burst_sampler_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_wake    (adc_wake),
    .adc_addr    (adc_addr),
    .adc_cs_n    (adc_cs_n),
    .adc_wr_n    (adc_wr_n),
    .adc_rd_n    (adc_rd_n),
    .smp_valid   (smp_valid),
    .timeout_err (timeout_err)
);

// File: tb/burst_sampler_bench.sv
module burst_sampler_bench;

    localparam int CLK_P   = 10;
    localparam int SLOTS   = 4;
    localparam int IVL_W   = 8;
    localparam int WAKE_C  = 4;
    localparam int ACQ_C   = 3;
    localparam int WR_C    = 2;
    localparam int RD_C    = 2;
    localparam int TO_C    = 12;
    localparam int INT_DLY = 3;

    // Vector: {burst_len[2:0], chan_list[11:0], interval[7:0]}
    localparam int NVEC = 6;
    localparam logic [22:0] VEC [NVEC] = '{
        {3'd4, 3'd7, 3'd3, 3'd0, 3'd5, 8'd6},
        {3'd1, 3'd0, 3'd0, 3'd0, 3'd2, 8'd3},
        {3'd0, 3'd1, 3'd1, 3'd1, 3'd6, 8'd0},
        {3'd7, 3'd7, 3'd4, 3'd2, 3'd1, 8'd9},
        {3'd3, 3'd5, 3'd6, 3'd7, 3'd0, 8'd2},
        {3'd2, 3'd0, 3'd0, 3'd1, 3'd7, 8'd4}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [IVL_W-1:0] interval = '0;
    logic [2:0]       burst_len = '0;
    logic [11:0]      chan_list = '0;
    logic             adc_wake, adc_cs_n, adc_wr_n, adc_rd_n;
    logic [2:0]       adc_addr;
    logic             adc_int_n = 1'b1;
    logic [7:0]       adc_data = '0;
    logic             smp_valid, timeout_err;
    logic [7:0]       smp_data;
    logic [2:0]       smp_chan;

    int tests = 0, fails = 0;

    burst_sampler #(
        .SLOTS (SLOTS), .IVL_W (IVL_W), .WAKE_CYC (WAKE_C), .ACQ_CYC (ACQ_C),
        .WR_CYC (WR_C), .RD_CYC (RD_C), .TIMEOUT_CYC (TO_C)
    ) u_burst_sampler (
        .clk (clk), .rst_n (rst_n), .enable (enable), .interval (interval),
        .burst_len (burst_len), .chan_list (chan_list), .adc_wake (adc_wake),
        .adc_addr (adc_addr), .adc_cs_n (adc_cs_n), .adc_wr_n (adc_wr_n),
        .adc_rd_n (adc_rd_n), .adc_int_n (adc_int_n), .adc_data (adc_data),
        .smp_valid (smp_valid), .smp_data (smp_data), .smp_chan (smp_chan),
        .timeout_err (timeout_err)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input logic [2:0] c);
        return (c == 3'd7) ? 8'hFF : {c, 5'b01010};
    endfunction

    // Converter model: flag low INT_DLY cycles after write rises, released by read/cs rise.
    logic       no_eoc = 1'b0;
    logic       m_wr_p = 1'b1, m_rd_p = 1'b1, m_cs_p = 1'b1;
    int         m_cd = 0;
    logic       m_busy = 1'b0;
    logic [2:0] m_code = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            adc_int_n <= 1'b1;
            m_busy = 1'b0;
        end else begin
            if (m_busy) begin
                m_cd--;
                if (m_cd == 0) begin
                    m_busy = 1'b0;
                    if (!no_eoc) begin
                        adc_int_n <= 1'b0;
                        adc_data  <= mbyte(m_code);
                    end
                end
            end
            if (!m_wr_p && adc_wr_n && !adc_cs_n) begin
                m_busy = 1'b1;
                m_cd   = INT_DLY;
                m_code = adc_addr;
            end
            if ((!m_rd_p && adc_rd_n) || (!m_cs_p && adc_cs_n)) adc_int_n <= 1'b1;
        end
        m_wr_p = adc_wr_n; m_rd_p = adc_rd_n; m_cs_p = adc_cs_n;
    end

    // Pin monitor: timing windows, stream capture, watchdog.
    logic [2:0] cap_chan [16];
    logic [7:0] cap_data [16];
    int   cap_n = 0, err_seen = 0, wr_falls = 0, cycles = 0;
    int   wake_hi = 0, addr_st = 0, since_int = 0, wr_lo = 0, rd_lo = 0;
    logic burst_first = 1'b0, int_seen = 1'b0;
    logic p_wake = 1'b0, p_cs = 1'b1, p_rd = 1'b1, p_wr = 1'b1, p_int = 1'b1;
    logic [2:0] p_addr = '0;
    always @(negedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
        if (rst_n) begin
            if (!p_wake && adc_wake) begin
                wake_hi = 0; burst_first = 1'b1; int_seen = 1'b0;
            end else if (adc_wake) wake_hi++;
            if (adc_addr != p_addr) addr_st = 0; else addr_st++;
            if (p_int && !adc_int_n) begin int_seen = 1'b1; since_int = 0; end
            else since_int++;
            if (p_wr && !adc_wr_n) begin
                wr_falls++;
                chk(addr_st >= ACQ_C, "R4 addr setup", addr_st, ACQ_C);
                if (burst_first)
                    chk(wake_hi >= WAKE_C + ACQ_C, "R3 wake delay", wake_hi, WAKE_C + ACQ_C);
                if (int_seen)
                    chk(since_int >= ACQ_C, "R5 acq spacing", since_int, ACQ_C);
                burst_first = 1'b0;
                wr_lo = 0;
            end
            if (!adc_wr_n) wr_lo++;
            if (!p_wr && adc_wr_n) begin
                chk(wr_lo == WR_C, "R6 write width", wr_lo, WR_C);
                chk(addr_st >= ACQ_C + WR_C, "R4 addr held", addr_st, ACQ_C + WR_C);
            end
            if (p_rd && !adc_rd_n) rd_lo = 0;
            if (!adc_rd_n) rd_lo++;
            if (!p_rd && adc_rd_n) chk(rd_lo == RD_C, "R6 read width", rd_lo, RD_C);
            if (p_wake && !adc_wake)
                chk(p_cs && p_rd && adc_cs_n, "R11 release before sleep", {p_cs, p_rd}, 3);
            if (smp_valid && cap_n < 16) begin
                cap_chan[cap_n] = smp_chan;
                cap_data[cap_n] = smp_data;
                cap_n++;
            end
            if (timeout_err) begin
                err_seen++;
                chk(adc_cs_n && adc_wr_n && adc_rd_n, "R10 strobes released", 0, 0);
            end
        end
        p_wake = adc_wake; p_cs = adc_cs_n; p_rd = adc_rd_n; p_wr = adc_wr_n;
        p_int = adc_int_n; p_addr = adc_addr;
    end

    // Apply a configuration at a wake-fall negedge and run one full burst.
    task automatic run_burst(input logic [22:0] v, input logic chk_sleep);
        int n;
        {burst_len, chan_list, interval} = v;
        cap_n = 0;
        n = 0;
        while (!adc_wake) begin n++; @(negedge clk); end
        if (chk_sleep) chk(n == int'(v[7:0]) + 1, "R2 sleep length", n, int'(v[7:0]) + 1);
        while (adc_wake) @(negedge clk);
    endtask

    task automatic check_items(input logic [22:0] v, input int skip, input string tag);
        int eff;
        logic [2:0] c;
        eff = (v[22:20] == 0) ? 1 : ((v[22:20] > SLOTS) ? SLOTS : int'(v[22:20]));
        chk(cap_n == eff - skip, tag, cap_n, eff - skip);
        for (int k = 0; k < eff - skip && k < cap_n; k++) begin
            c = v[8 + 3*(k+skip) +: 3];
            chk(cap_chan[k] == c, {tag, " chan"}, cap_chan[k], c);
            chk(cap_data[k] == mbyte(c), {tag, " data"}, cap_data[k], mbyte(c));
        end
    endtask

    initial begin
        logic [22:0] dv;
        int e0, w0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!adc_wake && adc_cs_n && adc_wr_n && adc_rd_n && !smp_valid && !timeout_err,
            "R1 in reset", 0, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!adc_wake && adc_cs_n && adc_wr_n && adc_rd_n && !smp_valid && !timeout_err,
            "R1 after reset", 0, 0);

        // R9 first result after reset dropped
        dv = {3'd3, 3'd0, 3'd6, 3'd2, 3'd4, 8'd2};
        enable = 1'b1;
        run_burst(dv, 1'b0);
        check_items(dv, 1, "R9 first dropped");

        // R7 R8 R2 vector table
        for (int i = 0; i < NVEC; i++) begin
            run_burst(VEC[i], 1'b1);
            check_items(VEC[i], 0, "R7 R8 burst");
        end

        // R10 missing end-of-conversion
        no_eoc = 1'b1;
        e0 = err_seen; w0 = wr_falls;
        dv = {3'd2, 3'd0, 3'd0, 3'd3, 3'd1, 8'd1};
        run_burst(dv, 1'b1);
        chk(err_seen == e0 + 1, "R10 error pulse", err_seen - e0, 1);
        chk(cap_n == 0, "R10 no sample", cap_n, 0);
        chk(wr_falls == w0 + 1, "R10 burst ended", wr_falls - w0, 1);
        no_eoc = 1'b0;
        run_burst(dv, 1'b1);
        check_items(dv, 0, "R10 recovery");

        // R2 enable low holds sleep
        enable = 1'b0;
        interval = 8'd0;
        w0 = 0;
        repeat (30) begin @(negedge clk); if (adc_wake) w0++; end
        chk(w0 == 0, "R2 enable low", w0, 0);
        enable = 1'b1;
        dv = {3'd1, 3'd0, 3'd0, 3'd0, 3'd7, 8'd3};
        run_burst(dv, 1'b1);
        check_items(dv, 0, "R7 full-scale code");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule